// File: doc/BRIEF.md
# GPIO Register Bank with Pad Crossbar

This block is a byte-wide register file that owns the control state of a set of numbered IO pads. Every IO can be set up from its own three-bit register, which holds an output enable, an output level and a read-only copy of the pad input. The same state is also visible through packed bank registers that carry eight IOs per byte. These three bit-level views share one store, so a value written through one view reads back through the others.

Each IO also has a crossbar register. In GPIO mode the pad is driven from its own enable and data bits. In routed mode the pad becomes an output that repeats the input of another numbered IO. Some IOs are built without crossbar support. Their crossbar registers stay fixed in GPIO mode. Three read-only locations return a model number and a revision. The serial front end and the pad cells sit outside the block. The block sees a plain address, write strobe and byte data. Read data is registered.

Top module: `gpx_regbank`

## Requirements
- R1: The per-IO register at address n (n below NUM_IO) returns bit 0 = output enable, bit 1 = output data, bit 2 = input, bits 7:3 = 0. A write updates only bits 0 and 1.
- R2: In GPIO mode, pad_oe[n] follows the output enable bit and pad_do[n] follows the output data bit. An enable of 1 makes the pad an output.
- R3: The bank output-data bytes start at 272 and the bank output-enable bytes start at 288. IO n sits in byte n/8 at bit n mod 8. A bank write is seen in the per-IO registers, and a per-IO write is seen in the bank bytes.
- R4: The bank input bytes start at 256 and use the same bit layout. They show the synchronized pad inputs and ignore writes.
- R5: A pad input reaches the register views after SYNC_STAGES clock edges of synchronization.
- R6: The crossbar register for IO n is at 128+n. Bit 7 = GPIO mode and bits 6:0 = source IO number. It resets to 0x80.
- R7: In routed mode (bit 7 = 0), pad_oe[n] = 1 and pad_do[n] = pad_di[source]. A source number of NUM_IO or more drives 0.
- R8: IOs without crossbar support (IO 0 to 3 by default) ignore crossbar writes, read 0x80 and stay in GPIO mode.
- R9: Address 304 reads 0x41, address 305 reads 0x00, and address 306 reads REVISION.
- R10: Unused addresses read 0x00 and ignore writes. This includes per-IO addresses at NUM_IO or above and bank bytes past the last IO.
- R11: While rst_n is low on a clock edge, every enable and data bit clears, so all pads are inputs.
- R12: reg_rdata shows the register selected by reg_addr one clock edge after the address is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 16 | Register address |
| reg_wr | input | 1 | Write strobe, one byte per cycle |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data |
| pad_di | input | NUM_IO | Pad input levels |
| pad_oe | output | NUM_IO | Pad output enables |
| pad_do | output | NUM_IO | Pad output levels |

## Verification
There are three timings to check. A write becomes visible at the next edge. reg_rdata needs one further edge after the address is applied. A pad input needs SYNC_STAGES edges before it reaches the registers, plus the read edge. The bench drives inputs at the falling edge and samples each read at the falling edge after its capturing rising edge. It waits four cycles after changing a pad input before it reads one. Pad outputs are combinational from the store and from pad_di, so the bench checks them a short delay after the input or write settles, never at an edge.

// File: rtl/gpx_pkg.sv
// Shared definitions for the GPIO register bank: address map and decode type.
// Assumes a 16-bit byte address and at most 128 IOs.
package gpx_pkg;

    localparam int ADDR_W      = 16;
    localparam int MAX_IO      = 128;
    localparam int BANK_BYTES  = 16;

    localparam int XBAR_BASE   = 128;
    localparam int BIN_BASE    = 256;
    localparam int BDO_BASE    = 272;
    localparam int BOE_BASE    = 288;
    localparam int ID_HI_ADDR  = 304;
    localparam int ID_LO_ADDR  = 305;
    localparam int REV_ADDR    = 306;

    typedef enum logic [3:0] {
        RG_NONE,
        RG_PIN,
        RG_XBAR,
        RG_BIN,
        RG_BDO,
        RG_BOE,
        RG_IDHI,
        RG_IDLO,
        RG_REV
    } region_e;

    typedef struct packed {
        region_e    region;
        logic [6:0] idx;
    } decode_t;

endpackage

// File: rtl/gpx_addr_decode.sv
// Address decoder: maps a byte address onto a register region and an index.
// Assumes NUM_IO <= 128. Indices past the implemented IOs or bank bytes
// decode as RG_NONE, which makes those addresses reserved.
module gpx_addr_decode
    import gpx_pkg::*;
#(
    parameter int NUM_IO = 48
) (
    input  logic [ADDR_W-1:0] addr,
    output decode_t           dec
);

    localparam int NUM_BYTES = (NUM_IO + 7) / 8;

    logic [ADDR_W-1:0] rel_xbar;
    logic [ADDR_W-1:0] rel_bin;
    logic [ADDR_W-1:0] rel_bdo;
    logic [ADDR_W-1:0] rel_boe;

    assign rel_xbar = addr - ADDR_W'(XBAR_BASE);
    assign rel_bin  = addr - ADDR_W'(BIN_BASE);
    assign rel_bdo  = addr - ADDR_W'(BDO_BASE);
    assign rel_boe  = addr - ADDR_W'(BOE_BASE);

    // Classify the address and extract the index within its region
    always_comb begin
        dec.region = RG_NONE;
        dec.idx    = '0;
        if (addr < ADDR_W'(XBAR_BASE)) begin
            if (addr < ADDR_W'(NUM_IO)) begin
                dec.region = RG_PIN;
                dec.idx    = addr[6:0];
            end
        end else if (addr < ADDR_W'(BIN_BASE)) begin
            if (rel_xbar < ADDR_W'(NUM_IO)) begin
                dec.region = RG_XBAR;
                dec.idx    = rel_xbar[6:0];
            end
        end else if (addr < ADDR_W'(BDO_BASE)) begin
            if (rel_bin < ADDR_W'(NUM_BYTES)) begin
                dec.region = RG_BIN;
                dec.idx    = rel_bin[6:0];
            end
        end else if (addr < ADDR_W'(BOE_BASE)) begin
            if (rel_bdo < ADDR_W'(NUM_BYTES)) begin
                dec.region = RG_BDO;
                dec.idx    = rel_bdo[6:0];
            end
        end else if (addr < ADDR_W'(BOE_BASE + BANK_BYTES)) begin
            if (rel_boe < ADDR_W'(NUM_BYTES)) begin
                dec.region = RG_BOE;
                dec.idx    = rel_boe[6:0];
            end
        end else if (addr == ADDR_W'(ID_HI_ADDR)) begin
            dec.region = RG_IDHI;
        end else if (addr == ADDR_W'(ID_LO_ADDR)) begin
            dec.region = RG_IDLO;
        end else if (addr == ADDR_W'(REV_ADDR)) begin
            dec.region = RG_REV;
        end
    end

endmodule

// File: rtl/gpx_input_sync.sv
// Multi-stage synchronizer for the pad inputs before they reach the
// register views. Assumes STAGES >= 1. Clears on reset.
module gpx_input_sync #(
    parameter int NUM_IO = 48,
    parameter int STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_IO-1:0] din,
    output logic [NUM_IO-1:0] dout
);

    logic [NUM_IO-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        // Shift one stage of the synchronizer chain
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                stage_q[s] <= '0;
            end else begin
                stage_q[s] <= (s == 0) ? din : stage_q[(s == 0) ? 0 : s - 1];
            end
        end
    end

    assign dout = stage_q[STAGES-1];

endmodule

// File: rtl/gpx_pin_store.sv
// Output-enable and output-data storage shared by the per-IO view and the
// two packed bank views. Per-IO writes touch bits 0 and 1. A bank write
// updates eight IOs from one byte. Assumes a one-cycle write strobe.
module gpx_pin_store
    import gpx_pkg::*;
#(
    parameter int NUM_IO = 48
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  decode_t           dec,
    input  logic [7:0]        wdata,
    output logic [NUM_IO-1:0] oe_q,
    output logic [NUM_IO-1:0] do_q
);

    localparam int FULL_BYTES = NUM_IO / 8;

    logic [NUM_IO-1:0] oe_n;
    logic [NUM_IO-1:0] do_n;

    // Merge writes from the per-IO view and the bank views into next state
    always_comb begin
        oe_n = oe_q;
        do_n = do_q;
        for (int n = 0; n < NUM_IO; n++) begin
            if (wr_en && dec.region == RG_PIN && dec.idx == 7'(n)) begin
                oe_n[n] = wdata[0];
                do_n[n] = wdata[1];
            end
            if (wr_en && dec.region == RG_BOE && dec.idx == 7'(n / 8)) begin
                oe_n[n] = wdata[n % 8];
            end
            if (wr_en && dec.region == RG_BDO && dec.idx == 7'(n / 8)) begin
                do_n[n] = wdata[n % 8];
            end
        end
    end

    // Hold the shared enable and data bits
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            oe_q <= '0;
            do_q <= '0;
        end else begin
            oe_q <= oe_n;
            do_q <= do_n;
        end
    end

    logic [MAX_IO-1:0] oe_wide;
    logic [MAX_IO-1:0] do_wide;
    assign oe_wide = MAX_IO'(oe_q);
    assign do_wide = MAX_IO'(do_q);

    // R1
    pin_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && dec.region == RG_PIN) |=>
            (oe_wide[$past(dec.idx)] == $past(wdata[0]) &&
             do_wide[$past(dec.idx)] == $past(wdata[1])));

    // R3
    bank_do_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && dec.region == RG_BDO && dec.idx < 7'(FULL_BYTES)) |=>
            (do_wide[{$past(dec.idx[3:0]), 3'b000} +: 8] == $past(wdata)));

    // R10
    store_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en || !(dec.region inside {RG_PIN, RG_BDO, RG_BOE})) |=>
            ($stable(oe_q) && $stable(do_q)));

endmodule

// File: rtl/gpx_xbar.sv
// Per-IO crossbar: a mode bit and a 7-bit source number for each IO, plus
// the pad output mux. In GPIO mode the pad follows its own bits. In routed
// mode the pad drives the raw input of the source IO, and a source with no
// IO behind it gives 0. IOs clear in XBAR_EN are fixed in GPIO mode.
module gpx_xbar
    import gpx_pkg::*;
#(
    parameter int                NUM_IO  = 48,
    parameter logic [NUM_IO-1:0] XBAR_EN = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  decode_t           dec,
    input  logic [7:0]        wdata,
    input  logic [NUM_IO-1:0] pad_di,
    input  logic [NUM_IO-1:0] gpio_oe,
    input  logic [NUM_IO-1:0] gpio_do,
    output logic [NUM_IO-1:0] pad_oe,
    output logic [NUM_IO-1:0] pad_do,
    output logic [7:0]        cfg_rd
);

    logic [MAX_IO-1:0] src_wide;
    logic [NUM_IO-1:0] mode_v;
    logic [6:0]        sel_v [NUM_IO];

    assign src_wide = MAX_IO'(pad_di);

    for (genvar n = 0; n < NUM_IO; n++) begin : g_io
        logic       m_q;
        logic [6:0] s_q;

        if (XBAR_EN[n]) begin : g_cfg
            // Crossbar setting of one IO, written at its own address
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    m_q <= 1'b1;
                    s_q <= '0;
                end else if (wr_en && dec.region == RG_XBAR && dec.idx == 7'(n)) begin
                    m_q <= wdata[7];
                    s_q <= wdata[6:0];
                end
            end

            // R6
            xbar_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (wr_en && dec.region == RG_XBAR && dec.idx == 7'(n)) |=>
                    ({m_q, s_q} == $past(wdata)));
        end else begin : g_fixed
            // IO without crossbar support stays in GPIO mode
            always_comb begin
                m_q = 1'b1;
                s_q = '0;
            end

            // R8
            xbar_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (pad_oe[n] == gpio_oe[n] && pad_do[n] == gpio_do[n]));
        end

        assign mode_v[n] = m_q;
        assign sel_v[n]  = s_q;

        // Pad mux: own bits in GPIO mode, else the selected input
        always_comb begin
            pad_oe[n] = m_q ? gpio_oe[n] : 1'b1;
            pad_do[n] = m_q ? gpio_do[n] : src_wide[s_q];
        end

        // R7
        routed_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!m_q && s_q >= 7'(NUM_IO)) |-> (pad_oe[n] && !pad_do[n]));
    end

    // Read-back of the crossbar register picked by the decoder
    always_comb begin
        cfg_rd = 8'h00;
        for (int n = 0; n < NUM_IO; n++) begin
            if (dec.region == RG_XBAR && dec.idx == 7'(n)) begin
                cfg_rd = {mode_v[n], sel_v[n]};
            end
        end
    end

endmodule

// File: rtl/gpx_regbank.sv
// GPIO register bank with pad crossbar. Byte bus in, registered read data
// out. The per-IO, bank and crossbar views all share the pin store.
// Assumes NUM_IO <= 128 and one access per cycle.
module gpx_regbank
    import gpx_pkg::*;
#(
    parameter int                NUM_IO      = 48,
    parameter int                SYNC_STAGES = 2,
    parameter logic [15:0]       MODEL_ID    = 16'h4100,
    parameter logic [7:0]        REVISION    = 8'h03,
    parameter logic [NUM_IO-1:0] XBAR_EN     = {{(NUM_IO-4){1'b1}}, 4'b0000}
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [15:0]       reg_addr,
    input  logic              reg_wr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    input  logic [NUM_IO-1:0] pad_di,
    output logic [NUM_IO-1:0] pad_oe,
    output logic [NUM_IO-1:0] pad_do
);

    decode_t           dec;
    logic [NUM_IO-1:0] oe_q;
    logic [NUM_IO-1:0] do_q;
    logic [NUM_IO-1:0] in_s;
    logic [7:0]        xbar_rd;
    logic [7:0]        rd_next;
    logic [7:0]        rdata_q;

    gpx_addr_decode #(.NUM_IO(NUM_IO)) u_dec (
        .addr (reg_addr),
        .dec  (dec)
    );

    gpx_input_sync #(.NUM_IO(NUM_IO), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (pad_di),
        .dout  (in_s)
    );

    gpx_pin_store #(.NUM_IO(NUM_IO)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (reg_wr),
        .dec   (dec),
        .wdata (reg_wdata),
        .oe_q  (oe_q),
        .do_q  (do_q)
    );

    gpx_xbar #(.NUM_IO(NUM_IO), .XBAR_EN(XBAR_EN)) u_xbar (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (reg_wr),
        .dec     (dec),
        .wdata   (reg_wdata),
        .pad_di  (pad_di),
        .gpio_oe (oe_q),
        .gpio_do (do_q),
        .pad_oe  (pad_oe),
        .pad_do  (pad_do),
        .cfg_rd  (xbar_rd)
    );

    logic [MAX_IO-1:0] oe_wide;
    logic [MAX_IO-1:0] do_wide;
    logic [MAX_IO-1:0] in_wide;
    assign oe_wide = MAX_IO'(oe_q);
    assign do_wide = MAX_IO'(do_q);
    assign in_wide = MAX_IO'(in_s);

    // Select the read byte for the decoded region
    always_comb begin
        unique case (dec.region)
            RG_PIN:  rd_next = {5'b0, in_wide[dec.idx], do_wide[dec.idx], oe_wide[dec.idx]};
            RG_XBAR: rd_next = xbar_rd;
            RG_BIN:  rd_next = in_wide[{dec.idx[3:0], 3'b000} +: 8];
            RG_BDO:  rd_next = do_wide[{dec.idx[3:0], 3'b000} +: 8];
            RG_BOE:  rd_next = oe_wide[{dec.idx[3:0], 3'b000} +: 8];
            RG_IDHI: rd_next = MODEL_ID[15:8];
            RG_IDLO: rd_next = MODEL_ID[7:0];
            RG_REV:  rd_next = REVISION;
            default: rd_next = 8'h00;
        endcase
    end

    // Register the read byte
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= 8'h00;
        end else begin
            rdata_q <= rd_next;
        end
    end

    assign reg_rdata = rdata_q;

    // R9
    id_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(reg_addr) == 16'(ID_HI_ADDR)) |-> (reg_rdata == MODEL_ID[15:8]));

    // R10
    reserved_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(dec.region) == RG_NONE) |-> (reg_rdata == 8'h00));

    // R11
    reset_pads_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (pad_oe == '0 && reg_rdata == 8'h00));

endmodule

// File: tb/tb_gpx_regbank.sv
module tb_gpx_regbank;

    localparam int         NUM_IO = 48;
    localparam logic [7:0] REV    = 8'h03;
    localparam int         NVEC   = 32;
    localparam int         WDOG   = 20000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [15:0]       reg_addr = '0;
    logic              reg_wr = 1'b0;
    logic [7:0]        reg_wdata = '0;
    logic [7:0]        reg_rdata;
    logic [NUM_IO-1:0] pad_di = '0;
    logic [NUM_IO-1:0] pad_oe;
    logic [NUM_IO-1:0] pad_do;

    int total = 0;
    int bad = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    gpx_regbank #(.NUM_IO(NUM_IO), .REVISION(REV)) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_addr  (reg_addr),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .pad_di    (pad_di),
        .pad_oe    (pad_oe),
        .pad_do    (pad_do)
    );

    // Vector: {write, addr, data, requirement}; write=1 writes data, else reads and expects data
    localparam logic [32:0] VECS [NVEC] = '{
        {1'b1, 16'd5,   8'h03, 8'd1},
        {1'b0, 16'd5,   8'h03, 8'd1},   // R1
        {1'b1, 16'd5,   8'hFB, 8'd1},
        {1'b0, 16'd5,   8'h03, 8'd1},   // R1 reserved and input bits not stored
        {1'b0, 16'd272, 8'h20, 8'd3},   // R3
        {1'b0, 16'd288, 8'h20, 8'd3},   // R3
        {1'b1, 16'd273, 8'hA5, 8'd3},
        {1'b0, 16'd8,   8'h02, 8'd3},   // R3
        {1'b0, 16'd9,   8'h00, 8'd3},   // R3
        {1'b0, 16'd10,  8'h02, 8'd3},   // R3
        {1'b1, 16'd289, 8'h0F, 8'd3},
        {1'b0, 16'd8,   8'h03, 8'd3},   // R3
        {1'b0, 16'd289, 8'h0F, 8'd3},   // R3
        {1'b0, 16'd304, 8'h41, 8'd9},   // R9
        {1'b0, 16'd305, 8'h00, 8'd9},   // R9
        {1'b0, 16'd306, REV,   8'd9},   // R9
        {1'b1, 16'd60,  8'h03, 8'd10},
        {1'b0, 16'd60,  8'h00, 8'd10},  // R10
        {1'b1, 16'd300, 8'hFF, 8'd10},
        {1'b0, 16'd300, 8'h00, 8'd10},  // R10
        {1'b0, 16'd278, 8'h00, 8'd10},  // R10 bank byte past last IO
        {1'b0, 16'd138, 8'h80, 8'd6},   // R6
        {1'b1, 16'd138, 8'h05, 8'd6},
        {1'b0, 16'd138, 8'h05, 8'd6},   // R6
        {1'b1, 16'd129, 8'h07, 8'd8},
        {1'b0, 16'd129, 8'h80, 8'd8},   // R8
        {1'b1, 16'd256, 8'hFF, 8'd4},
        {1'b0, 16'd256, 8'h00, 8'd4},   // R4
        {1'b0, 16'd272, 8'h20, 8'd4},   // R4 store untouched
        {1'b0, 16'd47,  8'h00, 8'd1},   // R1
        {1'b1, 16'd277, 8'h80, 8'd3},
        {1'b0, 16'd47,  8'h02, 8'd3}    // R3
    };

    task automatic check(input bit ok, input int req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL R%0d actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr  = a;
        reg_wdata = d;
        reg_wr    = 1'b1;
        @(negedge clk);
        reg_wr    = 1'b0;
    endtask

    task automatic rd(input logic [15:0] a, input logic [7:0] exp, input int req);
        @(negedge clk);
        reg_addr = a;
        @(posedge clk);
        @(negedge clk);
        check(reg_rdata == exp, req, reg_rdata, exp);
    endtask

    // Watchdog: a hung run counts as a failure
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles == WDOG) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=%0d expected=<%0d", cycles, WDOG);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R11 reset state
        check(pad_oe == '0, 11, int'(pad_oe[31:0]), 0);
        check(pad_do == '0, 11, int'(pad_do[31:0]), 0);
        rd(16'd272, 8'h00, 11);
        rd(16'd130, 8'h80, 6);   // R6 reset value

        for (int i = 0; i < NVEC; i++) begin
            if (VECS[i][32]) wr(VECS[i][31:16], VECS[i][15:8]);
            else             rd(VECS[i][31:16], VECS[i][15:8], int'(VECS[i][7:0]));
        end

        // R2 GPIO-mode pads follow own bits
        #1;
        check(pad_oe[5] && pad_do[5], 2, {pad_oe[5], pad_do[5]}, 3);
        check(!pad_oe[47] && pad_do[47], 2, {pad_oe[47], pad_do[47]}, 1);
        check(pad_oe[8] && pad_do[8], 2, {pad_oe[8], pad_do[8]}, 3);

        // R7 IO 10 routed from IO 5
        @(negedge clk);
        pad_di[5] = 1'b1;
        #1;
        check(pad_oe[10] && pad_do[10], 7, {pad_oe[10], pad_do[10]}, 3);
        @(negedge clk);
        pad_di[5] = 1'b0;
        #1;
        check(pad_oe[10] && !pad_do[10], 7, {pad_oe[10], pad_do[10]}, 2);

        // R7 out-of-range source drives 0
        wr(16'd138, 8'h7F);
        pad_di = '1;
        #1;
        check(pad_oe[10] && !pad_do[10], 7, {pad_oe[10], pad_do[10]}, 2);
        pad_di = '0;

        // R6 back to GPIO mode: own bits (oe from 0x0F bit2, do from 0xA5 bit2)
        wr(16'd138, 8'h80);
        #1;
        check(pad_oe[10] && pad_do[10], 6, {pad_oe[10], pad_do[10]}, 3);
        // R8 IO 1 stayed in GPIO mode with enable 0
        check(!pad_oe[1], 8, pad_oe[1], 0);

        // R5 / R4 synchronized input
        @(negedge clk);
        pad_di[20] = 1'b1;
        repeat (4) @(negedge clk);
        rd(16'd20, 8'h04, 5);
        rd(16'd258, 8'h10, 4);
        wr(16'd258, 8'h00);
        rd(16'd258, 8'h10, 4);

        // R12 read data lags address by one edge
        rd(16'd305, 8'h00, 12);
        @(negedge clk);
        reg_addr = 16'd304;
        #1;
        check(reg_rdata == 8'h00, 12, reg_rdata, 0);
        @(negedge clk);
        check(reg_rdata == 8'h41, 12, reg_rdata, 8'h41);

        // R11 reset mid-run clears the store
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check(pad_oe == '0, 11, int'(pad_oe[31:0]), 0);
        rd(16'd5, 8'h00, 11);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule